// File: doc/BRIEF.md
# Interpolating Gamma Curve Stage

This block applies a separate tone curve to each colour of an RGB pixel stream. All curves sit in one table written from a host bus. The table holds two curve sets: one for compression and one for expansion. Each set has one curve per channel, and each curve stores a few evenly spaced knots. For every pixel, the upper input bits pick a segment. The lower bits are a fraction, used to interpolate linearly between the two knots that bound that segment. A small table can therefore serve a wide input word, and the output width is a parameter that does not depend on the input width.

The block takes one pixel per cycle, qualified by a valid strobe, along with frame-sync and line-sync markers. The result appears two cycles later, and the markers are delayed by the same amount. A mode input picks compression or expansion. The block samples it only on the first pixel of a frame, so one frame never mixes curves. Host writes go to a memory with a separate write port. They can land in any cycle without holding up the pixel path.

Top module: `gamma_lut_stage`

## Requirements
- R1: While rst_ni is low, valid_o, fsync_o, lsync_o and pix_o are all zero.
- R2: valid_o, fsync_o and lsync_o equal valid_i, fsync_i and lsync_i from two cycles earlier. The pixel result for an input appears in the same cycle as its delayed valid.
- R3: An input whose fraction bits (the low IN_W-SEG_BITS bits) are zero produces exactly the knot selected by its upper SEG_BITS bits.
- R4: Any other input produces lo + floor((hi - lo) * frac / 2^(IN_W-SEG_BITS)), where lo and hi are knots idx and idx+1. This holds for falling curves (hi < lo) too.
- R5: Each curve has 2^SEG_BITS + 1 knots. Inputs in the top segment interpolate towards the extra end knot at index 2^SEG_BITS.
- R6: Red is pix bits [IN_W-1:0], green the next IN_W bits and blue the top IN_W bits. Each channel uses only its own curve.
- R7: The curve set is taken from mode_i (0 compression, 1 expansion) when valid_i and fsync_i are both high. That pixel and every later pixel use this set until the next such pixel. A change of mode_i mid-frame has no effect.
- R8: Table address fields are: knot index in cfg_addr_i[SEG_BITS:0], channel in [SEG_BITS+2:SEG_BITS+1] (0 red, 1 green, 2 blue), and curve set in bit [SEG_BITS+3]. Writes with channel 3, or with a knot index above 2^SEG_BITS, change no curve.
- R9: A table write in the same cycle as a pixel neither delays nor alters that pixel when the pixel does not read the written knot. The written value is used by every later pixel.
- R10: pix_o holds its value in cycles where valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Curve set request: 0 compression, 1 expansion |
| valid_i | input | 1 | Input pixel valid |
| fsync_i | input | 1 | First pixel of a frame |
| lsync_i | input | 1 | First pixel of a line |
| pix_i | input | 3*IN_W | Input pixel {blue, green, red} |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | SEG_BITS+4 | Table write address {set, channel, knot} |
| cfg_wdata_i | input | OUT_W | Knot value |
| valid_o | output | 1 | Output pixel valid |
| fsync_o | output | 1 | Delayed frame-sync |
| lsync_o | output | 1 | Delayed line-sync |
| pix_o | output | 3*OUT_W | Output pixel {blue, green, red} |

## Verification
A wrong held curve set shows up on the next pixel's data, two cycles after it enters. This is clearest just after a mid-frame mode change, where the two curves differ by more than 100 codes. A wrong knot index, fraction split or end-knot address makes the result leave the lo/hi interval, or miss the exact knot on aligned inputs. The bench probes both knot-aligned and full-scale codes to expose this. A write decode that aliases onto a live curve corrupts a known knot, which the next probe of that knot reveals.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  typedef enum logic {
    DIR_COMPRESS = 1'b0,
    DIR_EXPAND   = 1'b1
  } dir_e;

  localparam int NUM_CH = 3;
endpackage

// File: rtl/gamma_frame_mode.sv
module gamma_frame_mode
  import gamma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_i,
  output dir_e dir_o
);
  dir_e dir_q;

  // first pixel of a frame already uses the newly requested set
  assign dir_o = start_i ? dir_e'(mode_i) : dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dir_q <= DIR_COMPRESS;
    else if (start_i) dir_q <= dir_e'(mode_i);
  end

  assert_dir_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(dir_q));

  assert_dir_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (dir_q == dir_e'($past(mode_i))));
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank
  import gamma_pkg::*;
#(
  parameter int SEG_BITS = 3,
  parameter int OUT_W    = 8
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic                wdir_i,
  input  logic [SEG_BITS:0]   widx_i,
  input  logic [OUT_W-1:0]    wdata_i,
  input  dir_e                rdir_i,
  input  logic [SEG_BITS-1:0] rseg_i,
  output logic [OUT_W-1:0]    lo_o,
  output logic [OUT_W-1:0]    hi_o
);
  localparam int NSEG    = 1 << SEG_BITS;
  localparam int ENTRIES = NSEG + 1;
  localparam int DEPTH   = 2 * ENTRIES;
  localparam int MEM_AW  = $clog2(DEPTH);

  logic [OUT_W-1:0]  mem [DEPTH];
  logic [MEM_AW-1:0] waddr, raddr;
  logic              wok;

  assign wok   = we_i && (widx_i <= (SEG_BITS+1)'(NSEG));
  assign waddr = MEM_AW'(widx_i) + (wdir_i ? MEM_AW'(ENTRIES) : '0);
  assign raddr = MEM_AW'(rseg_i) + ((rdir_i == DIR_EXPAND) ? MEM_AW'(ENTRIES) : '0);

  // separate write port: host writes never block the read side
  always_ff @(posedge clk_i) begin
    if (wok) mem[waddr] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    lo_o <= mem[raddr];
    hi_o <= mem[raddr + MEM_AW'(1)];
  end
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp #(
  parameter int OUT_W  = 8,
  parameter int FRAC_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [OUT_W-1:0]  lo_i,
  input  logic [OUT_W-1:0]  hi_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [OUT_W-1:0]  y_o
);
  localparam int PW = OUT_W + FRAC_W + 2;

  logic signed [OUT_W:0]  diff;
  logic signed [PW-1:0]   prod;
  logic signed [PW-1:0]   sum;
  logic [OUT_W-1:0]       y_d;

  assign diff = $signed({1'b0, hi_i}) - $signed({1'b0, lo_i});
  assign prod = PW'(diff) * PW'($signed({1'b0, frac_i}));
  // arithmetic shift floors, result stays inside [min(lo,hi), max(lo,hi)]
  assign sum  = PW'($signed({1'b0, lo_i})) + (prod >>> FRAC_W);
  assign y_d  = OUT_W'(sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (en_i) y_o <= y_d;
  end

  assert_interp_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((y_o >= $past(lo_i)) || (y_o >= $past(hi_i))) &&
             ((y_o <= $past(lo_i)) || (y_o <= $past(hi_i))));

  assert_interp_knot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && frac_i == '0) |=> (y_o == $past(lo_i)));
endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
  import gamma_pkg::*;
#(
  parameter int IN_W     = 10,
  parameter int OUT_W    = 8,
  parameter int SEG_BITS = 3,
  localparam int ADDR_W  = SEG_BITS + 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_i,
  input  logic                  valid_i,
  input  logic                  fsync_i,
  input  logic                  lsync_i,
  input  logic [3*IN_W-1:0]     pix_i,
  input  logic                  cfg_we_i,
  input  logic [ADDR_W-1:0]     cfg_addr_i,
  input  logic [OUT_W-1:0]      cfg_wdata_i,
  output logic                  valid_o,
  output logic                  fsync_o,
  output logic                  lsync_o,
  output logic [3*OUT_W-1:0]    pix_o
);
  localparam int FRAC_W = IN_W - SEG_BITS;

  dir_e                cur_dir;
  logic                start;
  logic [SEG_BITS:0]   cfg_idx;
  logic [1:0]          cfg_ch;
  logic                cfg_dir;
  logic                v1, fs1, ls1;
  logic [1:0]          age_q;

  assign start   = valid_i & fsync_i;
  assign cfg_idx = cfg_addr_i[SEG_BITS:0];
  assign cfg_ch  = cfg_addr_i[SEG_BITS+2:SEG_BITS+1];
  assign cfg_dir = cfg_addr_i[SEG_BITS+3];

  gamma_frame_mode u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .mode_i  (mode_i),
    .dir_o   (cur_dir)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; fs1 <= 1'b0; ls1 <= 1'b0;
      valid_o <= 1'b0; fsync_o <= 1'b0; lsync_o <= 1'b0;
    end else begin
      v1 <= valid_i; fs1 <= fsync_i; ls1 <= lsync_i;
      valid_o <= v1; fsync_o <= fs1; lsync_o <= ls1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SEG_BITS-1:0] seg;
    logic [FRAC_W-1:0]   frac, frac1;
    logic [OUT_W-1:0]    lo, hi;

    assign seg  = pix_i[c*IN_W + IN_W - 1 -: SEG_BITS];
    assign frac = pix_i[c*IN_W +: FRAC_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) frac1 <= '0;
      else         frac1 <= frac;
    end

    gamma_lut_bank #(.SEG_BITS(SEG_BITS), .OUT_W(OUT_W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (cfg_we_i && (cfg_ch == 2'(c))),
      .wdir_i  (cfg_dir),
      .widx_i  (cfg_idx),
      .wdata_i (cfg_wdata_i),
      .rdir_i  (cur_dir),
      .rseg_i  (seg),
      .lo_o    (lo),
      .hi_o    (hi)
    );

    gamma_interp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_interp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (v1),
      .lo_i   (lo),
      .hi_i   (hi),
      .frac_i (frac1),
      .y_o    (pix_o[c*OUT_W +: OUT_W])
    );
  end

  // cycles since reset, saturating; only guards the latency check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_sync_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (valid_o == $past(valid_i, 2)) &&
                        (fsync_o == $past(fsync_i, 2)) &&
                        (lsync_o == $past(lsync_i, 2)));

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pix_o));
endmodule

// File: tb/sim_gamma_lut_stage.sv
module sim_gamma_lut_stage;
  localparam int IN_W = 10;
  localparam int OUT_W = 8;
  localparam int SEG_BITS = 3;
  localparam int FRAC_W = IN_W - SEG_BITS;
  localparam int NSEG = 1 << SEG_BITS;
  localparam int ADDR_W = SEG_BITS + 4;
  localparam int NV = 6;
  // {lsync, fsync, blue, green, red}
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b1, 10'd1023, 10'd128, 10'd0},
    {1'b0, 1'b0, 10'd1000, 10'd129, 10'd64},
    {1'b0, 1'b0, 10'd896,  10'd0,   10'd1023},
    {1'b0, 1'b0, 10'd1,    10'd555, 10'd300},
    {1'b1, 1'b0, 10'd1022, 10'd895, 10'd127},
    {1'b0, 1'b0, 10'd50,   10'd768, 10'd512}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_i = 1'b0, valid_i = 1'b0, fsync_i = 1'b0, lsync_i = 1'b0;
  logic [3*IN_W-1:0] pix_i = '0;
  logic cfg_we_i = 1'b0;
  logic [ADDR_W-1:0] cfg_addr_i = '0;
  logic [OUT_W-1:0] cfg_wdata_i = '0;
  logic valid_o, fsync_o, lsync_o;
  logic [3*OUT_W-1:0] pix_o;

  int tab [2][3][NSEG+1];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gamma_lut_stage #(.IN_W(IN_W), .OUT_W(OUT_W), .SEG_BITS(SEG_BITS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .valid_i(valid_i),
    .fsync_i(fsync_i), .lsync_i(lsync_i), .pix_i(pix_i), .cfg_we_i(cfg_we_i),
    .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .valid_o(valid_o),
    .fsync_o(fsync_o), .lsync_o(lsync_o), .pix_o(pix_o)
  );

  function automatic int model(int d, int c, int x);
    int i, f, lo, hi;
    i = x >> FRAC_W;
    f = x & ((1 << FRAC_W) - 1);
    lo = tab[d][c][i];
    hi = tab[d][c][i+1];
    return lo + (((hi - lo) * f) >>> FRAC_W);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int d, int c, int idx, int val, bit upd);
    @(negedge clk);
    cfg_we_i = 1'b1;
    cfg_addr_i = {1'(d), 2'(c), 4'(idx)};
    cfg_wdata_i = OUT_W'(val);
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (upd) tab[d][c][idx] = val;
  endtask

  task automatic check_pix(string req, int d, int r, int g, int b);
    chk(req, int'(pix_o[0 +: OUT_W]), model(d, 0, r));
    chk(req, int'(pix_o[OUT_W +: OUT_W]), model(d, 1, g));
    chk(req, int'(pix_o[2*OUT_W +: OUT_W]), model(d, 2, b));
  endtask

  // one isolated pixel; result sampled two edges later
  task automatic px(string req, bit fs, bit md, int d, int r, int g, int b);
    @(negedge clk);
    valid_i = 1'b1; fsync_i = fs; mode_i = md;
    pix_i = {IN_W'(b), IN_W'(g), IN_W'(r)};
    @(negedge clk);
    valid_i = 1'b0; fsync_i = 1'b0;
    @(negedge clk);
    chk(req, int'(valid_o), 1);
    check_pix(req, d, r, g, b);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3*OUT_W-1:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid_o", int'(valid_o), 0);
    chk("R1 fsync_o", int'(fsync_o), 0);
    chk("R1 lsync_o", int'(lsync_o), 0);
    chk("R1 pix_o", int'(pix_o), 0);
    rst_ni = 1'b1;

    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 3; c++)
        for (int e = 0; e <= NSEG; e++)
          wr(d, c, e, (d == 0) ? e * 30 + c * 4 : 255 - e * 28 - c * 3, 1);

    // streamed frame on compression curves: R2 R3 R4 R5 R6
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R2 valid_o", int'(valid_o), 1);
        chk("R2 fsync_o", int'(fsync_o), int'(VEC[i-2][30]));
        chk("R2 lsync_o", int'(lsync_o), int'(VEC[i-2][31]));
        check_pix("R3 R4 R5 R6 data", 0, int'(VEC[i-2][9:0]),
                  int'(VEC[i-2][19:10]), int'(VEC[i-2][29:20]));
      end
      if (i < NV) begin
        valid_i = 1'b1; fsync_i = VEC[i][30]; lsync_i = VEC[i][31];
        pix_i = VEC[i][29:0];
      end else begin
        valid_i = 1'b0; fsync_i = 1'b0; lsync_i = 1'b0;
      end
    end
    @(negedge clk);
    chk("R2 valid_o idle", int'(valid_o), 0);

    // R7 curve set follows frame start only
    px("R7 expand at frame start", 1, 1, 1, 700, 333, 1023);
    px("R7 mid-frame mode ignored", 0, 0, 1, 100, 900, 5);
    px("R7 compress at next frame", 1, 0, 0, 100, 900, 5);

    // R8 invalid writes change nothing
    wr(0, 3, 2, 8'hAA, 0);
    wr(0, 0, 12, 8'hAA, 0);
    wr(1, 3, 8, 8'h55, 0);
    px("R8 knot 2 intact", 0, 0, 0, 256, 256, 256);
    px("R8 end knot intact", 0, 0, 0, 1023, 1023, 1023);
    px("R8 expand end knot intact", 1, 1, 1, 1023, 1023, 0);

    // R9 write alongside a pixel
    @(negedge clk);
    valid_i = 1'b1; fsync_i = 1'b1; mode_i = 1'b0;
    pix_i = {10'd256, 10'd300, 10'd256};
    cfg_we_i = 1'b1; cfg_addr_i = {1'b0, 2'd1, 4'd5}; cfg_wdata_i = 8'd77;
    @(negedge clk);
    valid_i = 1'b0; fsync_i = 1'b0; cfg_we_i = 1'b0;
    @(negedge clk);
    chk("R9 valid_o not delayed", int'(valid_o), 1);
    check_pix("R9 pixel during write", 0, 256, 300, 256);
    tab[0][1][5] = 77;
    px("R9 new knot used", 0, 0, 0, 0, 640, 0);
    px("R9 new knot interpolated", 0, 0, 0, 0, 700, 0);

    // R10 hold while idle
    held = pix_o;
    repeat (3) @(negedge clk);
    chk("R10 pix_o held", int'(pix_o), int'(held));
    chk("R10 valid_o low", int'(valid_o), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule